// File: doc/BRIEF.md
# Paged Upper ROM Bus Responder

This block sits on the bus of an 8-bit Z80-style processor and acts as a small set of paged upper ROM banks. All bus lines are brought into a fast internal clock through two-flop synchronisers. When the processor starts a memory cycle, the block waits a fixed number of internal clocks before it looks at the ROM-enable line. That line settles a little later than memory-request, so it is not sampled on the same edge. A cycle where ROM-enable is still high at that point is left alone; DRAM refresh is the usual case. A cycle that ends before the sample point is also left alone.

Software picks the bank by writing a bank number to a fixed IO port. The block drives a read only when that number names one of the banks it holds. It then presents a byte from its 16 KB window and raises its output enable. The enable drops within a few internal clocks after memory-request returns high. The ROM contents are out of scope here. A computed fill pattern stands in for the storage so that each byte depends on both its address and its bank.

Top module: `rom_pager`

## Requirements
- R1: After reset the output enable `data_oe_o` is low and the bank register holds 0xFF, which names no held bank, so memory reads get no answer until the register is written.
- R2: A memory read (`mreq_ni`=0, `rd_ni`=0, `romen_ni`=0 at the sample point) while a held bank is selected raises `data_oe_o` and drives `data_o` = addr[7:0] XOR {addr[13:8],2'b00} XOR bank. The value stays stable while the enable is high.
- R3: A memory cycle with `romen_ni` high at the sample point, such as refresh, leaves `data_oe_o` low.
- R4: `romen_ni` is sampled SAMPLE_DLY (default 3) internal clocks after the synchronised fall of `mreq_ni`. A ROM-enable that falls 2 clocks after memory-request is accepted. One that falls 8 clocks after is ignored for that cycle.
- R5: An IO write (`iorq_ni`=0, `wr_ni`=0) to the full 16-bit address 0xDF00 loads the bank register from `data_i`.
- R6: IO writes to any other address, and IO reads of 0xDF00, leave the bank register unchanged.
- R7: The held banks are 6 and 7 by default. With any other bank selected, reads leave `data_oe_o` low.
- R8: `data_oe_o` falls no later than 3 internal clocks after `mreq_ni` rises.
- R9: A memory cycle whose `mreq_ni` low time ends before the sample point is not answered.
- R10: Address bits above bit 13 do not affect the byte driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_ni | input | 1 | Memory request, active low |
| romen_ni | input | 1 | ROM enable, active low |
| iorq_ni | input | 1 | IO request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Bus data in, used for IO writes |
| data_o | output | 8 | ROM byte, zero when not driving |
| data_oe_o | output | 1 | Data output enable, tristate control |

## Verification
The assertions assume that address, data, read and write are steady for several clocks around each strobe. They also assume that no IO write to the bank port overlaps a memory cycle the block is driving. The bench changes inputs only on falling clock edges. It holds each memory strobe low for 12 clocks, except in the short-cycle case, and holds each IO write for 6 clocks. It never starts an IO cycle and a memory cycle together. ROM-enable timing relative to memory-request is the one value the bench varies, and it places that edge on both sides of the sample point.

// File: rtl/rom_pager_pkg.sv
package rom_pager_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rom_select.sv
module rom_select #(
  parameter int                          ADDR_W   = 16,
  parameter int                          DATA_W   = 8,
  parameter int                          N_BANKS  = 2,
  parameter logic [N_BANKS*DATA_W-1:0]   BANK_IDS = {8'd7, 8'd6},
  parameter logic [ADDR_W-1:0]           SEL_PORT = 16'hDF00,
  parameter logic [DATA_W-1:0]           SEL_RST  = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iorq_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sel_o,
  output logic              hit_o
);
  logic [DATA_W-1:0]  sel_q;
  logic [N_BANKS-1:0] match;
  logic               wr_hit;

  // full 16-bit decode, active-low strobes
  assign wr_hit = !iorq_i && !wr_i && (addr_i == SEL_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SEL_RST;
    else if (wr_hit) sel_q <= data_i;
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign match[b] = (sel_q == BANK_IDS[b*DATA_W +: DATA_W]);
  end

  assign hit_o = |match;
  assign sel_o = sel_q;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(sel_q)); // R6
endmodule

// File: rtl/cycle_qual.sv
module cycle_qual
  import rom_pager_pkg::*;
#(
  parameter int SAMPLE_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mreq_i,
  input  logic romen_i,
  input  logic rd_i,
  input  logic hit_i,
  output logic load_o,
  output logic drive_o
);
  localparam int CNT_W = $clog2(SAMPLE_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DLY - 1);

  cyc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mreq_d;
  logic             mreq_fall;
  logic             at_sample;
  logic             accept;

  assign mreq_fall = mreq_d && !mreq_i;
  assign at_sample = (state_q == ST_WAIT) && !mreq_i && (cnt_q == CNT_LAST);
  assign accept    = !romen_i && !rd_i && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mreq_d <= 1'b1;
    else         mreq_d <= mreq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (mreq_fall) begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end
        ST_WAIT: begin
          if (mreq_i)         state_q <= ST_IDLE;
          else if (at_sample) state_q <= accept ? ST_DRIVE : ST_IDLE;
          else                cnt_q   <= cnt_q + 1'b1;
        end
        ST_DRIVE: if (mreq_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o  = at_sample && accept;
  assign drive_o = (state_q == ST_DRIVE);

  AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) && (cnt_q != CNT_LAST) |=> state_q != ST_DRIVE); // R4
  AST_SHORT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) && mreq_i |=> state_q == ST_IDLE); // R9
endmodule

// File: rtl/rom_pager.sv
module rom_pager #(
  parameter int                        ADDR_W     = 16,
  parameter int                        DATA_W     = 8,
  parameter int                        ROM_AW     = 14,
  parameter int                        N_BANKS    = 2,
  parameter logic [N_BANKS*DATA_W-1:0] BANK_IDS   = {8'd7, 8'd6},
  parameter logic [ADDR_W-1:0]         SEL_PORT   = 16'hDF00,
  parameter logic [DATA_W-1:0]         SEL_RST    = 8'hFF,
  parameter int                        SYNC_STAGES = 2,
  parameter int                        SAMPLE_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_ni,
  input  logic              romen_ni,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int CTL_W = 5;
  localparam int HI_W  = ROM_AW - DATA_W;

  logic [CTL_W-1:0]  ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              sync_mreq, sync_romen, sync_iorq, sync_rd, sync_wr;
  logic [DATA_W-1:0] sel;
  logic              sel_hit;
  logic              load, drive;
  logic [DATA_W-1:0] rom_byte;
  logic [DATA_W-1:0] data_q;

  bus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) i_sync_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mreq_ni, romen_ni, iorq_ni, rd_ni, wr_ni}),
    .q_o   (ctl_s)
  );

  bus_sync #(.W(ADDR_W + DATA_W), .STAGES(SYNC_STAGES)) i_sync_bus (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i}),
    .q_o   ({addr_s, din_s})
  );

  assign {sync_mreq, sync_romen, sync_iorq, sync_rd, sync_wr} = ctl_s;

  rom_select #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_BANKS(N_BANKS),
    .BANK_IDS(BANK_IDS), .SEL_PORT(SEL_PORT), .SEL_RST(SEL_RST)
  ) i_rom_select (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .iorq_i(sync_iorq),
    .wr_i  (sync_wr),
    .addr_i(addr_s),
    .data_i(din_s),
    .sel_o (sel),
    .hit_o (sel_hit)
  );

  cycle_qual #(.SAMPLE_DLY(SAMPLE_DLY)) i_cycle_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mreq_i (sync_mreq),
    .romen_i(sync_romen),
    .rd_i   (sync_rd),
    .hit_i  (sel_hit),
    .load_o (load),
    .drive_o(drive)
  );

  // stand-in storage: computed fill, bank-dependent
  assign rom_byte = addr_s[DATA_W-1:0]
                  ^ (DATA_W'(addr_s[ROM_AW-1:DATA_W]) << (DATA_W - HI_W))
                  ^ sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (load) data_q <= rom_byte;
  end

  assign data_oe_o = drive;
  assign data_o    = drive ? data_q : '0;

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_mreq) |-> !data_oe_o); // R8
  AST_ROMEN_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(!sync_romen)); // R3
  AST_HELD_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(sel_hit)); // R7
  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o && $past(data_oe_o) |-> $stable(data_o)); // R2
endmodule

// File: tb/test_rom_pager.sv
module test_rom_pager;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mreq_ni = 1'b1, romen_ni = 1'b1, iorq_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  rom_pager i_rom_pager (
    .clk_i(clk_i), .rst_ni(rst_ni), .mreq_ni(mreq_ni), .romen_ni(romen_ni),
    .iorq_ni(iorq_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .addr_i(addr_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  typedef struct packed {
    logic [7:0]  sel;
    logic [15:0] addr;
    logic        romen_lo;
    logic [3:0]  lag;
    logic        exp_oe;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd6, 16'h0000, 1'b1, 4'd0, 1'b1, 8'd2},  // R2
    '{8'd6, 16'h3FFF, 1'b1, 4'd0, 1'b1, 8'd2},  // R2
    '{8'd7, 16'h1234, 1'b1, 4'd2, 1'b1, 8'd4},  // R4 lag accepted
    '{8'd7, 16'h2A55, 1'b0, 4'd0, 1'b0, 8'd3},  // R3 refresh
    '{8'd5, 16'h0100, 1'b1, 4'd0, 1'b0, 8'd7},  // R7 unheld
    '{8'd7, 16'h0ABC, 1'b1, 4'd8, 1'b0, 8'd4},  // R4 late
    '{8'd6, 16'hC001, 1'b1, 4'd0, 1'b1, 8'd10}  // R10
  };

  function automatic logic [7:0] exp_byte(logic [15:0] a, logic [7:0] s);
    return a[7:0] ^ {a[13:8], 2'b00} ^ s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic io_cyc(logic [15:0] a, logic [7:0] d, logic is_wr);
    @(negedge clk_i);
    addr_i = a; data_i = d; iorq_ni = 1'b0;
    if (is_wr) wr_ni = 1'b0; else rd_ni = 1'b0;
    repeat (6) @(negedge clk_i);
    iorq_ni = 1'b1; wr_ni = 1'b1; rd_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  // returns whether oe was seen, the driven byte, and oe 3 clocks after release
  task automatic mem_cyc(logic [15:0] a, logic romen_lo, int lag, int hold,
                         output logic oe_any, output logic [7:0] dat, output logic oe_after);
    oe_any = 1'b0; dat = '0;
    @(negedge clk_i);
    addr_i = a; mreq_ni = 1'b0; rd_ni = 1'b0;
    for (int i = 0; i < hold; i++) begin
      if (romen_lo && i == lag) romen_ni = 1'b0;
      @(negedge clk_i);
      if (data_oe_o) begin oe_any = 1'b1; dat = data_o; end
    end
    mreq_ni = 1'b1; romen_ni = 1'b1; rd_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    oe_after = data_oe_o;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic oe, oe_after;
    logic [7:0] d;

    repeat (3) @(negedge clk_i);
    check("R1 oe in reset", 32'(data_oe_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 oe after reset", 32'(data_oe_o), 0);
    mem_cyc(16'h0010, 1'b1, 0, 12, oe, d, oe_after);
    check("R1 silent before select write", 32'(oe), 0);

    for (int v = 0; v < NV; v++) begin
      io_cyc(16'hDF00, VECS[v].sel, 1'b1);  // R5
      mem_cyc(VECS[v].addr, VECS[v].romen_lo, int'(VECS[v].lag), 12, oe, d, oe_after);
      check($sformatf("R%0d vec%0d oe", VECS[v].req, v), 32'(oe), 32'(VECS[v].exp_oe));
      if (VECS[v].exp_oe) begin
        check($sformatf("R5 R%0d vec%0d data", VECS[v].req, v), 32'(d),
              32'(exp_byte(VECS[v].addr, VECS[v].sel)));
        check($sformatf("R8 vec%0d release", v), 32'(oe_after), 0);
      end
    end

    // bank is 6 after last vector; R6: write to another port ignored
    io_cyc(16'hDF00, 8'd5, 1'b1);
    io_cyc(16'hDF01, 8'd6, 1'b1);
    mem_cyc(16'h0020, 1'b1, 0, 12, oe, d, oe_after);
    check("R6 other port write ignored", 32'(oe), 0);
    io_cyc(16'hDF00, 8'd7, 1'b0);
    mem_cyc(16'h0020, 1'b1, 0, 12, oe, d, oe_after);
    check("R6 io read ignored", 32'(oe), 0);

    // R5 with bank 7, then R9 short cycle
    io_cyc(16'hDF00, 8'd7, 1'b1);
    mem_cyc(16'h0030, 1'b1, 0, 3, oe, d, oe_after);
    check("R9 short cycle silent", 32'(oe), 0);
    mem_cyc(16'h0030, 1'b1, 0, 12, oe, d, oe_after);
    check("R5 bank 7 selected oe", 32'(oe), 1);
    check("R5 bank 7 data", 32'(d), 32'(exp_byte(16'h0030, 8'd7)));
    check("R8 release", 32'(oe_after), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule